// File: doc/BRIEF.md
# Configuration Image Stream Loader

This block moves a configuration image out of a byte-wide memory and into the configuration port of a programmable target device. The port takes 16-bit words. On a start pulse the loader scans the image for the two-byte start marker and drops everything in front of it. It then checks that the rest of the image has an even length and that the configuration store reports itself present. Only after these checks does it begin programming.

Each programming attempt has four steps. First it pulses the target's local-bus reset, then its configuration reload line, then its program pin. Next it waits for the target to raise its init flag. It then streams the payload as big-endian words and waits for the done flag. The pace of the writes depends on a version nibble that is sampled when init is seen. In handshaked mode each write waits for a transmit-ready flag. In fixed mode each write is preceded by a fixed gap. After every word the init flag must still be high. A failed attempt restarts the whole sequence, up to a bounded number of attempts. All pulse widths and poll spacings are counted in units of a clock prescaler, so a simulation can shorten them.

Top module: `cfg_stream_loader`

## Requirements
- R1: The payload starts at the first byte position holding 0xFF that is directly followed by 0x20. The marker pair is streamed as the first word, 0xFF20. Bytes in front of the marker are never written.
- R2: If no marker pair exists, or the byte count from the marker to the image end is odd, the result code is 1 (bad image). In that case no reset, reload or program pulse is issued and no word is written.
- R3: If the image is well formed but `store_ok` is low, the result code is 2 (no store). No pulse is issued and no word is written.
- R4: An attempt raises `bus_rst_o`, then `reload_o`, then `prog_o`, in that order and never two at once. Each pin stays high for at least PULSE_UNITS×UNIT_CYC cycles, followed by a low settle period of the same length.
- R5: After the program pulse, `stat_init` is polled up to INIT_POLLS times, SLOW_UNITS×UNIT_CYC cycles apart. If it never reads high, the attempt fails with code 4 (timeout).
- R6: Each written word is {byte[k], byte[k+1]}, with the lower address in bits 15:8. Words are written in ascending address order and one per `wr_stb` cycle.
- R7: If `stat_ver` equals 4'h5 when init is first seen, every write happens in the cycle after `stat_txrdy` was sampled high. `stat_txrdy` is polled up to TX_POLLS times, FAST_UNITS×UNIT_CYC cycles apart, and a miss fails the attempt with code 4.
- R8: For any other version nibble, `stat_txrdy` is ignored. Consecutive writes are at least GAP_UNITS×UNIT_CYC cycles apart.
- R9: If `stat_init` reads low in the cycle after a write, the attempt fails with code 3 (init lost). No further word of that attempt is written.
- R10: After the last word, `stat_done` is polled up to DONE_POLLS times, SLOW_UNITS×UNIT_CYC cycles apart. On success one more reset pulse and one more reload pulse are issued, with no program pulse, and the result code is 0. A miss fails the attempt with code 4.
- R11: At most ATTEMPTS attempts are made per start, each one a full restart from the reset pulse. The reported code is the failure of the last attempt. An attempt that succeeds after earlier failures reports 0.
- R12: `busy` is high from the cycle after an accepted start until the result is latched. `res_valid` and `err_code` then hold until the next start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| img_len | input | ADDR_W | Image length in bytes, sampled at start |
| mem_addr | output | ADDR_W | Image memory byte address |
| mem_data | input | 8 | Image byte at `mem_addr`, same cycle |
| store_ok | input | 1 | Configuration store present |
| stat_init | input | 1 | Target init flag |
| stat_txrdy | input | 1 | Target ready for the next word |
| stat_ver | input | 4 | Target version nibble |
| stat_done | input | 1 | Target configuration done flag |
| bus_rst_o | output | 1 | Local-bus reset pulse |
| reload_o | output | 1 | Configuration reload pulse |
| prog_o | output | 1 | Program pin pulse |
| wr_stb | output | 1 | Word write strobe |
| wr_data | output | 16 | Word written with `wr_stb` |
| busy | output | 1 | Sequence in progress |
| res_valid | output | 1 | Result latched |
| err_code | output | 3 | 0 ok, 1 bad image, 2 no store, 3 init lost, 4 timeout |

## Verification
Most faults in this block surface only late, as a wrong code or a wrong count of program pulses. The scan pointer and pacing mode are the exceptions. A stale scan pointer shows at the very first `wr_stb` as a wrong word, because the marker must arrive first. A wrong pacing mode shows within two writes, either as a gap that is too short or as a write with `stat_txrdy` low. A miscounted retry or poll counter shows only when the result is latched, many hundreds of cycles later. For that reason the pin order and the number of program pulses are logged for every run.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [2:0] {
    RES_OK         = 3'd0,
    RES_BAD_IMAGE  = 3'd1,
    RES_NO_STORE   = 3'd2,
    RES_INIT_LOST  = 3'd3,
    RES_TIMEOUT    = 3'd4
  } res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_CHECK, S_PULSE, S_INIT_POLL, S_FETCH_HI, S_FETCH_LO,
    S_TX_POLL, S_WRITE, S_POST, S_DONE_POLL, S_WAIT, S_FAIL
  } st_e;

  localparam logic [7:0] MARK_FIRST  = 8'hFF;
  localparam logic [7:0] MARK_SECOND = 8'h20;
  localparam logic [3:0] HS_SIG      = 4'h5;

  function automatic logic [15:0] pack_word(input logic [7:0] b_lo_addr,
                                            input logic [7:0] b_hi_addr);
    return {b_lo_addr, b_hi_addr};
  endfunction

  function automatic logic tail_is_odd(input logic [31:0] len,
                                       input logic [31:0] pos);
    logic [31:0] rem;
    rem = len - pos;
    return rem[0];
  endfunction

endpackage

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
  parameter int UNIT_CYC = 2,
  parameter int UW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [UW-1:0] units,
  output logic          fire
);
  localparam int CW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
  localparam logic [CW-1:0] CYC_TOP = CW'(UNIT_CYC - 1);

  logic          running;
  logic [CW-1:0] cyc_cnt;
  logic [UW-1:0] unit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cyc_cnt  <= '0;
      unit_cnt <= '0;
      fire     <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        running  <= 1'b1;
        cyc_cnt  <= CYC_TOP;
        unit_cnt <= units;
      end else if (running) begin
        if (cyc_cnt == '0) begin
          if (unit_cnt <= UW'(1)) begin
            running <= 1'b0;
            fire    <= 1'b1;
          end else begin
            unit_cnt <= unit_cnt - UW'(1);
            cyc_cnt  <= CYC_TOP;
          end
        end else begin
          cyc_cnt <= cyc_cnt - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cfg_ld_scan.sv
module cfg_ld_scan
  import cfg_ld_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] len,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] addr,
  output logic          fin,
  output logic          found,
  output logic [AW-1:0] pos
);
  logic          active;
  logic          prev_first;
  logic [AW-1:0] idx;

  assign addr = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      prev_first <= 1'b0;
      idx        <= '0;
      fin        <= 1'b0;
      found      <= 1'b0;
      pos        <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        active     <= 1'b1;
        prev_first <= 1'b0;
        idx        <= '0;
      end else if (active) begin
        if (idx == len) begin
          active <= 1'b0;
          fin    <= 1'b1;
          found  <= 1'b0;
        end else if (prev_first && byte_in == MARK_SECOND) begin
          active <= 1'b0;
          fin    <= 1'b1;
          found  <= 1'b1;
          pos    <= idx - AW'(1);
        end else begin
          prev_first <= (byte_in == MARK_FIRST);
          idx        <= idx + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_ld_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int UNIT_CYC    = 2,
  parameter int PULSE_UNITS = 4,
  parameter int SLOW_UNITS  = 3,
  parameter int FAST_UNITS  = 1,
  parameter int GAP_UNITS   = 5,
  parameter int INIT_POLLS  = 50,
  parameter int TX_POLLS    = 100,
  parameter int DONE_POLLS  = 200,
  parameter int ATTEMPTS    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] img_len,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  input  logic              store_ok,
  input  logic              stat_init,
  input  logic              stat_txrdy,
  input  logic [3:0]        stat_ver,
  input  logic              stat_done,
  output logic              bus_rst_o,
  output logic              reload_o,
  output logic              prog_o,
  output logic              wr_stb,
  output logic [15:0]       wr_data,
  output logic              busy,
  output logic              res_valid,
  output logic [2:0]        err_code
);
  localparam int MAX_UNITS = (PULSE_UNITS > GAP_UNITS) ?
                             ((PULSE_UNITS > SLOW_UNITS) ? PULSE_UNITS : SLOW_UNITS) :
                             ((GAP_UNITS > SLOW_UNITS) ? GAP_UNITS : SLOW_UNITS);
  localparam int UW    = $clog2(MAX_UNITS + 1);
  localparam int MAXP  = (DONE_POLLS > TX_POLLS) ?
                         ((DONE_POLLS > INIT_POLLS) ? DONE_POLLS : INIT_POLLS) :
                         ((TX_POLLS > INIT_POLLS) ? TX_POLLS : INIT_POLLS);
  localparam int PW    = $clog2(MAXP + 1);
  localparam int AT_W  = $clog2(ATTEMPTS + 1);
  localparam logic [UW-1:0] U_PULSE = UW'(PULSE_UNITS);
  localparam logic [UW-1:0] U_SLOW  = UW'(SLOW_UNITS);
  localparam logic [UW-1:0] U_FAST  = UW'(FAST_UNITS);
  localparam logic [UW-1:0] U_GAP   = UW'(GAP_UNITS);

  st_e               st, ret_st;
  logic [1:0]        ph;
  logic              ph_hi, final_q, mode_hs, found_q;
  logic [AT_W-1:0]   attempt;
  logic [PW-1:0]     poll;
  res_e              fail_code, err_q;
  logic [ADDR_W-1:0] wi, len_q, pos_q;
  logic [7:0]        hi_byte;
  logic [15:0]       word_q;

  logic              tm_load, tm_fire, scan_go, scan_fin, scan_found;
  logic [UW-1:0]     tm_units;
  logic [ADDR_W-1:0] scan_addr, scan_pos;

  cfg_ld_timer #(.UNIT_CYC(UNIT_CYC), .UW(UW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .units(tm_units), .fire(tm_fire));

  cfg_ld_scan #(.AW(ADDR_W)) scan_i (
    .clk(clk), .rst_n(rst_n), .go(scan_go), .len(len_q), .byte_in(mem_data),
    .addr(scan_addr), .fin(scan_fin), .found(scan_found), .pos(scan_pos));

  // named event wires, also used by the checker
  logic ev_write, ev_last_word, ev_reject;
  assign ev_write     = (st == S_WRITE);
  assign ev_last_word = (wi + ADDR_W'(2) == len_q);
  assign ev_reject    = !found_q || tail_is_odd(32'(len_q), 32'(pos_q));

  always_comb begin
    unique case (st)
      S_SCAN:     mem_addr = scan_addr;
      S_FETCH_LO: mem_addr = wi + ADDR_W'(1);
      default:    mem_addr = wi;
    endcase
  end

  assign bus_rst_o = (st == S_PULSE) && ph_hi && (ph == 2'd0);
  assign reload_o  = (st == S_PULSE) && ph_hi && (ph == 2'd1);
  assign prog_o    = (st == S_PULSE) && ph_hi && (ph == 2'd2);
  assign wr_stb    = ev_write;
  assign wr_data   = word_q;
  assign busy      = (st != S_IDLE);
  assign err_code  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;       ret_st <= S_IDLE;
      ph <= '0;           ph_hi <= 1'b0;     final_q <= 1'b0;
      mode_hs <= 1'b0;    found_q <= 1'b0;   attempt <= '0;
      poll <= '0;         fail_code <= RES_OK; err_q <= RES_OK;
      wi <= '0;           len_q <= '0;       pos_q <= '0;
      hi_byte <= '0;      word_q <= '0;      res_valid <= 1'b0;
      tm_load <= 1'b0;    tm_units <= '0;    scan_go <= 1'b0;
    end else begin
      tm_load <= 1'b0;
      scan_go <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          len_q     <= img_len;
          res_valid <= 1'b0;
          attempt   <= '0;
          scan_go   <= 1'b1;
          st        <= S_SCAN;
        end
        S_SCAN: if (scan_fin) begin
          found_q <= scan_found;
          pos_q   <= scan_pos;
          st      <= S_CHECK;
        end
        S_CHECK: begin
          if (ev_reject) begin
            err_q <= RES_BAD_IMAGE; res_valid <= 1'b1; st <= S_IDLE;
          end else if (!store_ok) begin
            err_q <= RES_NO_STORE; res_valid <= 1'b1; st <= S_IDLE;
          end else begin
            ph <= 2'd0; ph_hi <= 1'b1; final_q <= 1'b0;
            tm_load <= 1'b1; tm_units <= U_PULSE; st <= S_PULSE;
          end
        end
        S_PULSE: if (tm_fire) begin
          if (ph_hi) begin
            ph_hi <= 1'b0; tm_load <= 1'b1; tm_units <= U_PULSE;
          end else if (final_q && ph == 2'd1) begin
            err_q <= RES_OK; res_valid <= 1'b1; st <= S_IDLE;
          end else if (ph == 2'd2) begin
            poll <= '0; st <= S_INIT_POLL;
          end else begin
            ph <= ph + 2'd1; ph_hi <= 1'b1; tm_load <= 1'b1; tm_units <= U_PULSE;
          end
        end
        S_INIT_POLL: begin
          if (stat_init) begin
            mode_hs <= (stat_ver == HS_SIG);
            wi      <= pos_q;
            st      <= S_FETCH_HI;
          end else if (poll == PW'(INIT_POLLS - 1)) begin
            fail_code <= RES_TIMEOUT; st <= S_FAIL;
          end else begin
            poll <= poll + PW'(1); tm_load <= 1'b1; tm_units <= U_SLOW;
            ret_st <= S_INIT_POLL; st <= S_WAIT;
          end
        end
        S_WAIT: if (tm_fire) st <= ret_st;
        S_FETCH_HI: begin
          hi_byte <= mem_data;
          st      <= S_FETCH_LO;
        end
        S_FETCH_LO: begin
          word_q <= pack_word(hi_byte, mem_data);
          if (mode_hs) begin
            poll <= '0; st <= S_TX_POLL;
          end else begin
            tm_load <= 1'b1; tm_units <= U_GAP; ret_st <= S_WRITE; st <= S_WAIT;
          end
        end
        S_TX_POLL: begin
          if (stat_txrdy) begin
            st <= S_WRITE;
          end else if (poll == PW'(TX_POLLS - 1)) begin
            fail_code <= RES_TIMEOUT; st <= S_FAIL;
          end else begin
            poll <= poll + PW'(1); tm_load <= 1'b1; tm_units <= U_FAST;
            ret_st <= S_TX_POLL; st <= S_WAIT;
          end
        end
        S_WRITE: st <= S_POST;
        S_POST: begin
          if (!stat_init) begin
            fail_code <= RES_INIT_LOST; st <= S_FAIL;
          end else if (ev_last_word) begin
            poll <= '0; st <= S_DONE_POLL;
          end else begin
            wi <= wi + ADDR_W'(2); st <= S_FETCH_HI;
          end
        end
        S_DONE_POLL: begin
          if (stat_done) begin
            final_q <= 1'b1; ph <= 2'd0; ph_hi <= 1'b1;
            tm_load <= 1'b1; tm_units <= U_PULSE; st <= S_PULSE;
          end else if (poll == PW'(DONE_POLLS - 1)) begin
            fail_code <= RES_TIMEOUT; st <= S_FAIL;
          end else begin
            poll <= poll + PW'(1); tm_load <= 1'b1; tm_units <= U_SLOW;
            ret_st <= S_DONE_POLL; st <= S_WAIT;
          end
        end
        S_FAIL: begin
          if (attempt == AT_W'(ATTEMPTS - 1)) begin
            err_q <= fail_code; res_valid <= 1'b1; st <= S_IDLE;
          end else begin
            attempt <= attempt + AT_W'(1);
            ph <= 2'd0; ph_hi <= 1'b1; final_q <= 1'b0;
            tm_load <= 1'b1; tm_units <= U_PULSE; st <= S_PULSE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_ld_chk.sv
module cfg_ld_chk #(
  parameter int ATTEMPTS = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       res_valid,
  input logic [2:0] err_code,
  input logic       bus_rst_o,
  input logic       reload_o,
  input logic       prog_o,
  input logic       wr_stb,
  input logic       stat_txrdy,
  input logic       mode_hs
);
  logic       touched, prog_q;
  logic [7:0] prog_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touched <= 1'b0; prog_q <= 1'b0; prog_cnt <= '0;
    end else begin
      prog_q <= prog_o;
      if (start && !busy) begin
        touched <= 1'b0; prog_cnt <= '0;
      end else begin
        if (bus_rst_o || reload_o || prog_o || wr_stb) touched <= 1'b1;
        if (prog_o && !prog_q) prog_cnt <= prog_cnt + 8'd1;
      end
    end
  end

  AST_ONE_PIN_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rst_o, reload_o, prog_o})); // R4

  AST_HS_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode_hs) |-> $past(stat_txrdy)); // R7

  AST_REJECT_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(res_valid) && (err_code == 3'd1 || err_code == 3'd2)) |-> !touched); // R2 R3

  AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    prog_cnt <= 8'(ATTEMPTS)); // R11

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !start) |=> (res_valid && $stable(err_code))); // R12

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (busy && !res_valid)); // R12
endmodule

bind cfg_stream_loader cfg_ld_chk #(.ATTEMPTS(ATTEMPTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .res_valid(res_valid),
  .err_code(err_code), .bus_rst_o(bus_rst_o), .reload_o(reload_o),
  .prog_o(prog_o), .wr_stb(wr_stb), .stat_txrdy(stat_txrdy), .mode_hs(mode_hs));

// File: tb/cfg_stream_loader_tb.sv
module cfg_stream_loader_tb_top;
  localparam int MIN_PULSE = 8;   // PULSE_UNITS*UNIT_CYC at defaults
  localparam int MIN_GAP   = 10;  // GAP_UNITS*UNIT_CYC at defaults

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, store_ok = 1'b1;
  logic [15:0] img_len = '0, mem_addr, wr_data;
  logic [7:0]  mem_data;
  logic stat_init, stat_txrdy, stat_done;
  logic [3:0] stat_ver = 4'h0;
  logic bus_rst_o, reload_o, prog_o, wr_stb, busy, res_valid;
  logic [2:0] err_code;

  always #2 clk = ~clk;  // 250 MHz

  logic [7:0] mem [0:63];
  assign mem_data = mem[mem_addr[5:0]];

  cfg_stream_loader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
    .mem_addr(mem_addr), .mem_data(mem_data), .store_ok(store_ok),
    .stat_init(stat_init), .stat_txrdy(stat_txrdy), .stat_ver(stat_ver),
    .stat_done(stat_done), .bus_rst_o(bus_rst_o), .reload_o(reload_o),
    .prog_o(prog_o), .wr_stb(wr_stb), .wr_data(wr_data), .busy(busy),
    .res_valid(res_valid), .err_code(err_code));

  // ---------------- target model ----------------
  int init_from = 1, init_dly = 20, lose_at = 0, done_at = 0, tx_mode = 0;
  bit done_en = 1'b1;
  int prog_cnt = 0, base = 0, icnt = 0, wcnt = 0, tgl = 0;
  logic prog_q = 1'b0, lost = 1'b0;

  always @(posedge clk) begin
    prog_q <= prog_o;
    tgl    <= tgl + 1;
    if (prog_o && !prog_q) prog_cnt <= prog_cnt + 1;
    if (prog_o) begin
      icnt <= 0; wcnt <= 0; lost <= 1'b0;
    end else begin
      if (icnt < 100000) icnt <= icnt + 1;
      if (wr_stb) begin
        wcnt <= wcnt + 1;
        if (wcnt + 1 == lose_at) lost <= 1'b1;
      end
    end
  end
  assign stat_init  = (prog_cnt - base >= init_from) && (icnt >= init_dly) && !lost && !prog_o;
  assign stat_done  = done_en && (prog_cnt > base) && (wcnt >= done_at) && !prog_o;
  assign stat_txrdy = (tx_mode == 0) ? 1'b1 : (tx_mode == 1) ? 1'b0 : (tgl % 3 == 0);

  // ---------------- checking infrastructure ----------------
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] exp_q[$];
  int pin_q[$];
  int last_wr = -1, min_gap = 1000000, min_prog = 1000000, prog_w = 0;
  logic rst_q = 1'b0, rld_q = 1'b0, prg_q2 = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: scoreboard pop, pin order, widths, gaps
  always @(negedge clk) if (rst_n) begin
    if (wr_stb) begin
      if (exp_q.size() == 0) chk("R6 unexpected write", int'(wr_data), 0);
      else chk("R6 word value", int'(wr_data), int'(exp_q.pop_front()));
      if (last_wr >= 0 && cyc - last_wr < min_gap) min_gap = cyc - last_wr;
      last_wr = cyc;
    end
    if (bus_rst_o && !rst_q) pin_q.push_back(0);
    if (reload_o && !rld_q) pin_q.push_back(1);
    if (prog_o && !prg_q2) pin_q.push_back(2);
    if (prog_o) prog_w++;
    else if (prg_q2) begin
      if (prog_w < min_prog) min_prog = prog_w;
      prog_w = 0;
    end
    rst_q = bus_rst_o; rld_q = reload_o; prg_q2 = prog_o;
  end

  // driver: restates the marker search its own way and queues expected words
  task automatic push_words(int len, int copies, int limit);
    int p = -1;
    for (int k = len - 2; k >= 0; k--)
      if (mem[k] == 8'hFF && mem[k+1] == 8'h20) p = k;
    for (int c = 0; c < copies; c++) begin
      int n = 0;
      for (int k = p; k + 1 < len && n < limit; k += 2) begin
        exp_q.push_back({mem[k], mem[k+1]});
        n++;
      end
    end
  endtask

  task automatic load(input logic [7:0] b[], output int len);
    foreach (b[k]) mem[k] = b[k];
    len = b.size();
  endtask

  task automatic run(string req, int len, int exp_code, int exp_att, int nwords);
    int t = 0;
    int exp_pins[$];
    base = prog_cnt; pin_q = {}; last_wr = -1; min_gap = 1000000;
    min_prog = 1000000; done_at = nwords;
    img_len = 16'(len);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({req, " busy after start R12"}, int'(busy), 1);
    while (!res_valid && t < 40000) begin @(negedge clk); t++; end
    chk({req, " result code"}, int'(err_code), exp_code);
    chk({req, " attempts R11"}, prog_cnt - base, exp_att);
    chk({req, " queue drained R6"}, exp_q.size(), 0);
    exp_q = {};
    for (int a = 0; a < exp_att; a++) begin
      exp_pins.push_back(0); exp_pins.push_back(1); exp_pins.push_back(2);
    end
    if (exp_code == 0) begin exp_pins.push_back(0); exp_pins.push_back(1); end
    chk({req, " pin count R4"}, pin_q.size(), exp_pins.size());
    for (int k = 0; k < exp_pins.size() && k < pin_q.size(); k++)
      chk({req, " pin order R4"}, pin_q[k], exp_pins[k]);
    if (exp_att > 0) chk({req, " prog width R4"}, int'(min_prog >= MIN_PULSE), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int len;
    logic [2:0] held;
    foreach (mem[k]) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk("reset busy R12", int'(busy), 0);
    chk("reset valid R12", int'(res_valid), 0);
    chk("reset pins R4", int'({bus_rst_o, reload_o, prog_o, wr_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R6 R7: header dropped, handshaked mode, toggling ready, restart ignored
    load('{8'h11, 8'h22, 8'h33, 8'hFF, 8'h20, 8'hAB, 8'hCD, 8'h01, 8'h02}, len);
    stat_ver = 4'h5; tx_mode = 2;
    push_words(len, 1, 99);
    fork
      run("R1 header skip", len, 0, 1, 3);
      begin repeat (40) @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; end
    join
    held = err_code;
    repeat (20) @(negedge clk);
    chk("R12 result held", int'(err_code), int'(held));
    chk("R12 valid held", int'(res_valid), 1);
    chk("R12 idle", int'(busy), 0);

    // R2: no marker
    load('{8'hFF, 8'h21, 8'h20, 8'hFF}, len);
    run("R2 no marker", len, 1, 0, 0);
    // R2: odd tail
    load('{8'h00, 8'hFF, 8'h20, 8'hAA, 8'h55, 8'h01}, len);
    run("R2 odd tail", len, 1, 0, 0);
    // R3: store missing
    load('{8'hFF, 8'h20, 8'h12, 8'h34}, len);
    store_ok = 1'b0;
    run("R3 no store", len, 2, 0, 0);
    store_ok = 1'b1;

    // R8 R1: fixed mode, ready never asserted, repeated first-marker byte
    load('{8'hFF, 8'hFF, 8'h20, 8'h12, 8'h34}, len);
    stat_ver = 4'h0; tx_mode = 1;
    push_words(len, 1, 99);
    run("R8 fixed pace", len, 0, 1, 2);
    chk("R8 gap", int'(min_gap >= MIN_GAP), 1);

    // R7: handshake never ready
    load('{8'hFF, 8'h20, 8'h12, 8'h34}, len);
    stat_ver = 4'h5; tx_mode = 1;
    run("R7 ready timeout", len, 4, 3, 2);
    tx_mode = 0;

    // R5: init never
    init_from = 99;
    run("R5 init timeout", len, 4, 3, 2);
    // R11: init only on the second attempt
    init_from = 2;
    push_words(len, 1, 99);
    run("R11 late success", len, 0, 2, 2);
    init_from = 1;

    // R9: init lost after word 2, every attempt
    load('{8'hFF, 8'h20, 8'h12, 8'h34, 8'h56, 8'h78}, len);
    lose_at = 2;
    push_words(len, 3, 2);
    run("R9 init lost", len, 3, 3, 3);
    lose_at = 0;

    // R10: done never
    done_en = 1'b0;
    push_words(len, 3, 99);
    run("R10 done timeout", len, 4, 3, 3);
    done_en = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule